// File: doc/BRIEF.md
# Indirect-Window Interrupt Routing Register File

This block holds the configuration state of an I/O interrupt router and makes it reachable from a 32-bit memory-mapped bus through only two bus words. The bus word at offset 0x00 is a selector: software writes a register number into it. The bus word at offset 0x10 is a data port: a read or write there reaches whichever internal register the selector currently names. Behind the port are a router identifier, a fixed version word, an arbitration identifier and a table of routing entries. Each routing entry is 64 bits wide and is reached as two consecutive 32-bit register numbers.

The block decodes every routing entry into its fields and drives them continuously on wide output buses, so dispatch logic never has to go through the bus. Two per-access flags report trouble. The first reports a bus access of the wrong width or at an offset other than the two words. The second reports a data-port access while the selector names a register that does not exist.

Top module: `ioroute_regs`

## Requirements
- R1: After reset the selector reads 0, the router ID and the arbitration ID both read INIT_ID in bits 27:24, every routing entry has its mask bit (bit 16) set and all its other bits zero.
- R2: An access is legal only with all four byte enables set and offset 0x00 or 0x10. Any other access raises `offsetErr` in that cycle, reads as zero and changes no state.
- R3: A legal write to offset 0x00 loads bits 7:0 into the selector. A read of offset 0x00 returns the selector zero-extended to 32 bits.
- R4: Register number 0 is the router ID. A write keeps bits 27:24. A read returns those bits in 27:24 and zero elsewhere.
- R5: Register number 1 is read-only. It reads 0x00170011: the entry count minus one (23) in bits 23:16 and 0x11 in bits 7:0. Writes to it change nothing.
- R6: Register number 2 is the arbitration ID. It is stored and read back in bits 27:24, independently of the router ID.
- R7: Routing entry n has its low word at register number 0x10+2n and its high word at 0x11+2n. Each word reads back what was stored.
- R8: A write to a low word clears every bit outside 0x0001AFFF. A write to a high word clears every bit outside 0xFF000000.
- R9: One cycle after a write, the field outputs of entry n show the new values. Vector is low bits 7:0, delivery mode is 10:8, destination mode is 11, polarity is 13, trigger mode is 15, mask is 16, and destination is high-word bits 31:24.
- R10: A data-port access while the selector holds 3..0x0F or 0x40 and above raises `indexWarn` in that cycle, reads as zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W (8) | Byte offset within the block |
| busBe | input | 4 | Byte enables; all four required |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle as the access |
| offsetErr | output | 1 | Illegal width or offset in this cycle |
| indexWarn | output | 1 | Data port reached an undefined register number |
| entVector | output | 8*N_ENT | Vector of each entry, entry n at [8n+:8] |
| entDelMode | output | 3*N_ENT | Delivery mode of each entry |
| entDestMode | output | N_ENT | Destination mode of each entry |
| entPolarity | output | N_ENT | Polarity of each entry |
| entTrigger | output | N_ENT | Trigger mode of each entry |
| entMask | output | N_ENT | Mask bit of each entry |
| entDest | output | 8*N_ENT | Destination of each entry |

## Verification
Directed sequences first walk every table slot with all-ones writes, which isolates the reserved-bit clearing of each half from the addressing of the pair. Writes of distinct field patterns to single entries then separate the field positions on the decoded buses. Illegal offsets, partial byte enables and undefined register numbers are followed by reads of the state they might have disturbed. A long pseudo-random mix of selector writes, data-port reads and writes, bad widths and bad offsets runs against a behavioural model. The model compares read data, both flags and every decoded field on every clock.

// File: rtl/ioroute_pkg.sv
package ioroute_pkg;
  localparam int SEL_W = 8;
  localparam int TBL_BASE = 16;
  // bits that survive a write in each half of a routing entry
  localparam logic [31:0] LO_KEEP  = 32'h0001_AFFF;
  localparam logic [31:0] HI_KEEP  = 32'hFF00_0000;
  localparam logic [31:0] LO_RESET = 32'h0001_0000;

  typedef enum logic [2:0] {
    RD_ZERO, RD_SEL, RD_ID, RD_VER, RD_ARB, RD_LO, RD_HI
  } rdSrc_e;

  typedef struct packed {
    logic       selWr;
    logic       idWr;
    logic       arbWr;
    logic       loWr;
    logic       hiWr;
    logic [7:0] entSel;
    rdSrc_e     rdSrc;
  } strobes_t;
endpackage

// File: rtl/ioroute_ctrl.sv
module ioroute_ctrl
  import ioroute_pkg::*;
#(
  parameter int N_ENT  = 24,
  parameter int ADDR_W = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic [SEL_W-1:0]  idxQ,
  output strobes_t          strb,
  output logic              offsetErr,
  output logic              indexWarn
);
  localparam int TBL_END = TBL_BASE + 2 * N_ENT;

  logic fullWord, atSel, atPort, legal, inTable;
  logic [SEL_W-1:0] tblOff;

  always_comb begin
    fullWord  = &busBe;
    atSel     = (busAddr == ADDR_W'(0));
    atPort    = (busAddr == ADDR_W'(16));
    legal     = busValid && fullWord && (atSel || atPort);
    offsetErr = busValid && !legal;
    tblOff    = idxQ - SEL_W'(TBL_BASE);
    inTable   = (int'(idxQ) >= TBL_BASE) && (int'(idxQ) < TBL_END);

    strb        = '0;
    strb.rdSrc  = RD_ZERO;
    strb.entSel = {1'b0, tblOff[SEL_W-1:1]};
    indexWarn   = 1'b0;

    if (legal && atSel) begin
      strb.selWr = busWrite;
      strb.rdSrc = RD_SEL;
    end else if (legal && atPort) begin
      if (idxQ == SEL_W'(0)) begin
        strb.idWr  = busWrite;
        strb.rdSrc = RD_ID;
      end else if (idxQ == SEL_W'(1)) begin
        strb.rdSrc = RD_VER;
      end else if (idxQ == SEL_W'(2)) begin
        strb.arbWr = busWrite;
        strb.rdSrc = RD_ARB;
      end else if (inTable) begin
        if (tblOff[0]) begin
          strb.hiWr  = busWrite;
          strb.rdSrc = RD_HI;
        end else begin
          strb.loWr  = busWrite;
          strb.rdSrc = RD_LO;
        end
      end else begin
        indexWarn = 1'b1;
      end
    end

    if (busWrite) strb.rdSrc = RD_ZERO;
  end
endmodule

// File: rtl/ioroute_dp.sv
module ioroute_dp
  import ioroute_pkg::*;
#(
  parameter int              N_ENT   = 24,
  parameter int              ID_W    = 4,
  parameter logic [ID_W-1:0] INIT_ID = 4'h1,
  parameter logic [7:0]      VER     = 8'h11
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [31:0]        busWdata,
  output logic [SEL_W-1:0]   idxQ,
  output logic [31:0]        rdData,
  output logic [8*N_ENT-1:0] entVector,
  output logic [3*N_ENT-1:0] entDelMode,
  output logic [N_ENT-1:0]   entDestMode,
  output logic [N_ENT-1:0]   entPolarity,
  output logic [N_ENT-1:0]   entTrigger,
  output logic [N_ENT-1:0]   entMask,
  output logic [8*N_ENT-1:0] entDest
);
  localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam logic [31:0] VER_WORD = {8'h00, 8'(N_ENT - 1), 8'h00, VER};

  logic [ID_W-1:0] idQ, arbQ;
  logic [31:0]     loQ [N_ENT];
  logic [31:0]     hiQ [N_ENT];
  logic [ENT_W-1:0] pick;

  assign pick = strb.entSel[ENT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
      idQ  <= INIT_ID;
      arbQ <= INIT_ID;
    end else begin
      if (strb.selWr) idxQ <= busWdata[SEL_W-1:0];
      if (strb.idWr)  idQ  <= busWdata[24 +: ID_W];
      if (strb.arbWr) arbQ <= busWdata[24 +: ID_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < N_ENT; e++) begin
        loQ[e] <= LO_RESET;
        hiQ[e] <= '0;
      end
    end else begin
      for (int e = 0; e < N_ENT; e++) begin
        if (strb.loWr && strb.entSel == 8'(e)) loQ[e] <= busWdata & LO_KEEP;
        if (strb.hiWr && strb.entSel == 8'(e)) hiQ[e] <= busWdata & HI_KEEP;
      end
    end
  end

  always_comb begin
    case (strb.rdSrc)
      RD_SEL:  rdData = 32'(idxQ);
      RD_ID:   rdData = 32'(idQ) << 24;
      RD_VER:  rdData = VER_WORD;
      RD_ARB:  rdData = 32'(arbQ) << 24;
      RD_LO:   rdData = loQ[pick];
      RD_HI:   rdData = hiQ[pick];
      default: rdData = '0;
    endcase
  end

  for (genvar g = 0; g < N_ENT; g++) begin : gField
    assign entVector[8*g +: 8]  = loQ[g][7:0];
    assign entDelMode[3*g +: 3] = loQ[g][10:8];
    assign entDestMode[g]       = loQ[g][11];
    assign entPolarity[g]       = loQ[g][13];
    assign entTrigger[g]        = loQ[g][15];
    assign entMask[g]           = loQ[g][16];
    assign entDest[8*g +: 8]    = hiQ[g][31:24];
  end
endmodule

// File: rtl/ioroute_regs.sv
module ioroute_regs
  import ioroute_pkg::*;
#(
  parameter int              N_ENT   = 24,
  parameter int              ADDR_W  = 8,
  parameter int              ID_W    = 4,
  parameter logic [ID_W-1:0] INIT_ID = 4'h1,
  parameter logic [7:0]      VER     = 8'h11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [3:0]         busBe,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               offsetErr,
  output logic               indexWarn,
  output logic [8*N_ENT-1:0] entVector,
  output logic [3*N_ENT-1:0] entDelMode,
  output logic [N_ENT-1:0]   entDestMode,
  output logic [N_ENT-1:0]   entPolarity,
  output logic [N_ENT-1:0]   entTrigger,
  output logic [N_ENT-1:0]   entMask,
  output logic [8*N_ENT-1:0] entDest
);
  strobes_t         strb;
  logic [SEL_W-1:0] idxQ;

  ioroute_ctrl #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) uCtrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busBe(busBe),
    .idxQ(idxQ), .strb(strb), .offsetErr(offsetErr), .indexWarn(indexWarn)
  );

  ioroute_dp #(.N_ENT(N_ENT), .ID_W(ID_W), .INIT_ID(INIT_ID), .VER(VER)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .idxQ(idxQ), .rdData(busRdata),
    .entVector(entVector), .entDelMode(entDelMode), .entDestMode(entDestMode),
    .entPolarity(entPolarity), .entTrigger(entTrigger), .entMask(entMask),
    .entDest(entDest)
  );
endmodule

// File: rtl/ioroute_chk.sv
module ioroute_chk #(
  parameter int N_ENT  = 24,
  parameter int ADDR_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [3:0]         busBe,
  input logic [31:0]        busWdata,
  input logic [31:0]        busRdata,
  input logic               offsetErr,
  input logic               indexWarn,
  input logic [8*N_ENT-1:0] entVector,
  input logic [N_ENT-1:0]   entMask,
  input logic [8*N_ENT-1:0] entDest,
  input logic [7:0]         idxQ
);
  // R2
  bad_offset_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    offsetErr |-> busRdata == 32'h0);

  // R2
  bad_offset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && offsetErr) |=> ($stable(entMask) && $stable(entVector) &&
                                 $stable(entDest) && $stable(idxQ)));

  // R10
  undef_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    indexWarn |-> (busRdata == 32'h0 && busValid && !offsetErr));

  // R10
  undef_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (indexWarn && busWrite) |=> ($stable(entMask) && $stable(entVector) &&
                                 $stable(entDest) && $stable(idxQ)));

  // R3
  sel_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && &busBe && busAddr == ADDR_W'(0)) |=>
      idxQ == $past(busWdata[7:0]));

  // R9
  entry0_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && &busBe && busAddr == ADDR_W'(16) && idxQ == 8'h10) |=>
      (entVector[7:0] == $past(busWdata[7:0]) && entMask[0] == $past(busWdata[16])));
endmodule

bind ioroute_regs ioroute_chk #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
  .offsetErr(offsetErr), .indexWarn(indexWarn), .entVector(entVector),
  .entMask(entMask), .entDest(entDest), .idxQ(idxQ)
);

// File: tb/tb_ioroute_regs.sv
module tb_ioroute_regs;
  localparam int N = 24;

  logic clk = 1'b0, rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [3:0] busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic offsetErr, indexWarn;
  logic [8*N-1:0] entVector, entDest;
  logic [3*N-1:0] entDelMode;
  logic [N-1:0] entDestMode, entPolarity, entTrigger, entMask;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ioroute_regs dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
    .offsetErr(offsetErr), .indexWarn(indexWarn), .entVector(entVector),
    .entDelMode(entDelMode), .entDestMode(entDestMode), .entPolarity(entPolarity),
    .entTrigger(entTrigger), .entMask(entMask), .entDest(entDest)
  );

  // behavioural reference model
  bit [31:0] mLo[N], mHi[N];
  bit [7:0]  mSel;
  bit [3:0]  mId, mArb;

  function automatic bit isLegal();
    return busValid && busBe == 4'hF && (busAddr == 8'h00 || busAddr == 8'h10);
  endfunction

  function automatic bit isUndef();
    if (!(isLegal() && busAddr == 8'h10)) return 0;
    return !(mSel <= 8'd2 || (mSel >= 8'h10 && mSel < 8'h10 + 2 * N));
  endfunction

  function automatic logic [31:0] expRead();
    int k;
    if (!isLegal() || busWrite) return 32'h0;
    if (busAddr == 8'h00) return {24'h0, mSel};
    if (mSel == 0) return {4'h0, mId, 24'h0};
    if (mSel == 1) return (32'(N - 1) << 16) | 32'h11;
    if (mSel == 2) return {4'h0, mArb, 24'h0};
    if (isUndef()) return 32'h0;
    k = (int'(mSel) - 16) / 2;
    return mSel[0] ? mHi[k] : mLo[k];
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSel = 0; mId = 4'h1; mArb = 4'h1;
      for (int e = 0; e < N; e++) begin mLo[e] = 32'h0001_0000; mHi[e] = 0; end
    end else if (isLegal() && busWrite) begin
      if (busAddr == 8'h00) mSel = busWdata[7:0];
      else if (mSel == 0) mId = busWdata[27:24];
      else if (mSel == 2) mArb = busWdata[27:24];
      else if (!isUndef() && mSel != 1) begin
        if (mSel[0]) mHi[(int'(mSel) - 16) / 2] = busWdata & 32'hFF00_0000;
        else         mLo[(int'(mSel) - 16) / 2] = busWdata & 32'h0001_AFFF;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [8*N-1:0] eV, eD;
      logic [3*N-1:0] eM;
      logic [N-1:0] eDm, eP, eT, eK;
      for (int e = 0; e < N; e++) begin
        eV[8*e +: 8] = mLo[e][7:0];
        eM[3*e +: 3] = mLo[e][10:8];
        eDm[e] = mLo[e][11];
        eP[e]  = mLo[e][13];
        eT[e]  = mLo[e][15];
        eK[e]  = mLo[e][16];
        eD[8*e +: 8] = mHi[e][31:24];
      end
      check(busRdata == expRead(), "R7 read data", busRdata, expRead());
      check(offsetErr == (busValid && !isLegal()), "R2 offsetErr", offsetErr,
            busValid && !isLegal());
      check(indexWarn == isUndef(), "R10 indexWarn", indexWarn, isUndef());
      check(entVector == eV && entDelMode == eM && entDest == eD, "R9 fields",
            {entVector, entDelMode}, {eV, eM});
      check(entDestMode == eDm && entPolarity == eP && entTrigger == eT && entMask == eK,
            "R9 flags", {entDestMode, entPolarity, entTrigger, entMask}, {eDm, eP, eT, eK});
    end
  end

  // one bus cycle; checks read data and flags at the falling edge
  task automatic xfer(input bit w, input logic [7:0] a, input logic [3:0] be,
                      input logic [31:0] d, input logic [31:0] expRd,
                      input bit expErr, input bit expWarn, input string tag);
    busValid = 1; busWrite = w; busAddr = a; busBe = be; busWdata = d;
    @(negedge clk);
    if (!w) check(busRdata == expRd, tag, busRdata, expRd);
    check(offsetErr == expErr && indexWarn == expWarn, tag, {offsetErr, indexWarn},
          {expErr, expWarn});
    @(posedge clk); #1;
    busValid = 0; busWrite = 0;
  endtask

  task automatic sel(input logic [7:0] s);
    xfer(1, 8'h00, 4'hF, {24'h0, s}, 0, 0, 0, "R3 select");
  endtask

  task automatic wr(input logic [31:0] d);
    xfer(1, 8'h10, 4'hF, d, 0, 0, 0, "R7 write");
  endtask

  task automatic rd(input logic [31:0] e, input string tag);
    xfer(0, 8'h10, 4'hF, 0, e, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    xfer(0, 8'h00, 4'hF, 0, 32'h0, 0, 0, "R1 selector");
    rd(32'h0100_0000, "R1 id");
    check(entMask == '1 && entVector == '0 && entDest == '0, "R1 entries",
          {entMask, entDest}, {{N{1'b1}}, {8*N{1'b0}}});
    sel(8'h02); rd(32'h0100_0000, "R1 arb");
    sel(8'h10); rd(32'h0001_0000, "R1 entry lo");
    sel(8'h11); rd(32'h0, "R1 entry hi");

    // R3 selector
    sel(8'hA7); xfer(0, 8'h00, 4'hF, 0, 32'h0000_00A7, 0, 0, "R3 readback");

    // R4 router ID
    sel(8'h00); wr(32'hFFFF_FFFF); rd(32'h0F00_0000, "R4 all ones");
    wr(32'hA5A5_A5A5); rd(32'h0500_0000, "R4 pattern");

    // R6 arbitration ID
    sel(8'h02); wr(32'h3C00_0000); rd(32'h0C00_0000, "R6 arb");
    sel(8'h00); rd(32'h0500_0000, "R6 id untouched");

    // R5 version
    sel(8'h01); rd(32'h0017_0011, "R5 version");
    wr(32'hFFFF_FFFF); rd(32'h0017_0011, "R5 write ignored");

    // R7 / R8 every slot
    for (int e = 0; e < N; e++) begin
      sel(8'(16 + 2 * e)); wr(32'hFFFF_FFFF); rd(32'h0001_AFFF, "R8 low half");
      sel(8'(17 + 2 * e)); wr(32'hFFFF_FFFF); rd(32'hFF00_0000, "R8 high half");
    end
    for (int e = 0; e < N; e++) begin
      sel(8'(16 + 2 * e)); wr(32'(e) * 32'h0000_0101 & 32'h0000_07FF);
      sel(8'(17 + 2 * e)); wr(32'(e) << 24);
    end
    for (int e = 0; e < N; e++) begin
      sel(8'(16 + 2 * e)); rd(32'(e) * 32'h0000_0101 & 32'h0000_07FF, "R7 low");
      sel(8'(17 + 2 * e)); rd(32'(e) << 24, "R7 high");
    end

    // R9 field positions on entry 7
    sel(8'h1E); wr(32'h0001_2B42);
    sel(8'h1F); wr(32'hC300_0000);
    check(entVector[56 +: 8] == 8'h42 && entDelMode[21 +: 3] == 3'd3, "R9 vec/mode",
          {entVector[56 +: 8], entDelMode[21 +: 3]}, {8'h42, 3'd3});
    check({entDestMode[7], entPolarity[7], entTrigger[7], entMask[7]} == 4'b1101,
          "R9 bits", {entDestMode[7], entPolarity[7], entTrigger[7], entMask[7]}, 4'b1101);
    check(entDest[56 +: 8] == 8'hC3, "R9 dest", entDest[56 +: 8], 8'hC3);

    // R10 undefined numbers
    sel(8'h03); xfer(1, 8'h10, 4'hF, 32'hFFFF_FFFF, 0, 0, 1, "R10 write 3");
    xfer(0, 8'h10, 4'hF, 0, 32'h0, 0, 1, "R10 read 3");
    sel(8'h0F); xfer(0, 8'h10, 4'hF, 0, 32'h0, 0, 1, "R10 read 0F");
    sel(8'h40); xfer(1, 8'h10, 4'hF, 32'hFFFF_FFFF, 0, 0, 1, "R10 write 40");
    sel(8'h3F); rd(32'h1700_0000, "R10 last entry untouched");

    // R2 illegal offsets and widths
    xfer(1, 8'h04, 4'hF, 32'h0000_0012, 0, 1, 0, "R2 offset 4 write");
    xfer(0, 8'h00, 4'hF, 0, 32'h0000_003F, 0, 0, "R2 selector kept");
    xfer(1, 8'h10, 4'h7, 32'h0000_0000, 0, 1, 0, "R2 partial write");
    rd(32'h1700_0000, "R2 entry kept");
    xfer(0, 8'h14, 4'hF, 0, 32'h0, 1, 0, "R2 offset 14 read");
    xfer(0, 8'h00, 4'h1, 0, 32'h0, 1, 0, "R2 narrow read");

    // pseudo-random mix checked by the model every clock
    for (int i = 0; i < 4000; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      busValid = lcg[31] | lcg[30];
      busWrite = lcg[29];
      case (lcg[28:26])
        3'd0, 3'd1: busAddr = 8'h00;
        3'd7:       busAddr = 8'h04;
        default:    busAddr = 8'h10;
      endcase
      busBe = (lcg[25:22] == 4'h0) ? 4'h3 : 4'hF;
      busWdata = (busAddr == 8'h00) ? {24'h0, 1'b0, lcg[14:8]} :
                 {lcg[7:0], lcg[21:0], lcg[23:22]};
      @(posedge clk); #1;
    end
    busValid = 0;
    @(posedge clk); #1;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule